// File: doc/BRIEF.md
# Display Controller Power Sequencer

This block brings an attached display controller up and down by issuing a fixed series of register writes to a serial writer. Each write carries a register address, a payload length of zero, one or two bytes, and the payload itself. The writer does the actual shifting and reports completion, with an error bit, on an acknowledge strobe. A step can also call for a wait of a number of milliseconds after its write completes. The millisecond base comes from a prescaler derived from the `CLK_HZ` parameter.

An enable request starts with a guarded wake-up preamble. It sends three bare commands to address 0x00, and each one is followed by a one-millisecond pause. If the writer flags an error on any of these, the run is abandoned before any configuration register is touched. Otherwise the sequencer goes on through the following steps:

- leaving deep standby
- the power and mode set-up writes
- a sleep-out command
- a group of configuration writes
- a final display-on command

After the display-on command the block reports itself active. Errors reported after the preamble are remembered in a sticky flag, but the run still completes.

A disable request runs a four-step shutdown and then reports the block disabled. A request that would not change the state is dropped. So is any request that arrives while a run is in progress.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset the block is idle and inactive: `busy`, `active`, `err_flag` and `wr_valid` are all 0.
- R2: An accepted enable request first issues three writes to address 0x00 with `wr_len` = 0. After each write is acknowledged, `wr_valid` stays low for at least CLK_HZ/1000 cycles.
- R3: If a preamble write is acknowledged with `wr_err` = 1, no further write is issued. `err_flag` becomes 1, `active` stays 0, and the block returns to idle.
- R4: After the preamble, the writes come in this order: 0xB0 with 0x17, 0xBC with 0x80, 0x3B with 0x00, 0xB0 with 0x16, 0xB8 with two bytes 0xFFF9, then 0x11 with no payload.
- R5: Configuration writes follow: 0xBA with 0x01, 0x3A with 0x60, 0xB6 with 0x40, then 0xEC with two bytes 0x01F0. The run ends with 0x29 with no payload, and `active` rises only after that write is acknowledged.
- R6: A write error after the preamble sets `err_flag`, but the enable run still issues every remaining write and ends active.
- R7: An accepted disable request issues 0x28 with no payload, 0xB8 with two bytes 0x8002, 0x10 with no payload, and 0xB0 with 0x00. After the last acknowledge, `active` falls to 0.
- R8: An enable request while active, or a disable request while inactive, starts no write and leaves `busy` at 0.
- R9: `busy` is 1 from the cycle after an accepted request until the run ends. Requests seen while `busy` is 1 are ignored.
- R10: `err_flag` holds its value while a run proceeds and while idle. It is cleared only when a new request is accepted.
- R11: Payload encoding: a `wr_len` of 0 means command only with `wr_data` = 0. A `wr_len` of 1 puts the byte in `wr_data[7:0]` with `wr_data[15:8]` = 0. A `wr_len` of 2 sends `wr_data[15:8]` first and then `wr_data[7:0]`. `wr_len` is never 3.
- R12: Once `wr_valid` is raised, it and `wr_addr`, `wr_len` and `wr_data` hold steady until the cycle in which `wr_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_req | input | 1 | Request to power the display up |
| disable_req | input | 1 | Request to power the display down |
| wr_valid | output | 1 | A register write is presented to the serial writer |
| wr_addr | output | 8 | Register address of the presented write |
| wr_len | output | 2 | Payload byte count (0, 1 or 2) |
| wr_data | output | 16 | Payload, high byte sent first when two bytes |
| wr_ack | input | 1 | Writer finished the presented write (one-cycle strobe) |
| wr_err | input | 1 | Writer reports a failed transfer, valid with `wr_ack` |
| busy | output | 1 | A sequence is running |
| active | output | 1 | Display is powered up and on |
| err_flag | output | 1 | Sticky transfer error of the last run |

## Verification
The assertions check the per-cycle rules on every cycle:

- the write handshake stays stable until acknowledged;
- the payload length encoding is legal;
- `active` changes only right after a display-on or final power-register write;
- a preamble error always ends in an idle, inactive, flagged state;
- the error flag is sticky while busy;
- out-of-state requests never leave the block busy.

Other properties need the bench's scenarios against its reference model: the exact order and values of the writes, the length of each millisecond pause, and that a mid-run error lets the enable run finish. The bench's scenarios also show that requests made during a run leave the final state and write log unchanged.

// File: rtl/dps_pkg.sv
package dps_pkg;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int LEN_W  = 2;
   localparam int DLY_W  = 2;

   // step table layout: enable run first, shutdown run after it
   localparam int PRE_COUNT = 3;
   localparam int EN_FIRST  = 0;
   localparam int EN_LAST   = 13;
   localparam int DIS_FIRST = 14;
   localparam int DIS_LAST  = 17;
   localparam int ROM_DEPTH = 18;

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [LEN_W-1:0]  len;
      logic [DATA_W-1:0] data;
      logic [DLY_W-1:0]  dly;
   } step_t;

   function automatic step_t mk(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                                input logic [DATA_W-1:0] d, input logic [DLY_W-1:0] w);
      step_t s;
      s.addr = a;
      s.len  = l;
      s.data = d;
      s.dly  = w;
      return s;
   endfunction

   function automatic step_t step_at(input int i);
      case (i)
         0, 1, 2: return mk(8'h00, 2'd0, 16'h0000, 2'd1);
         3:  return mk(8'hB0, 2'd1, 16'h0017, 2'd0);
         4:  return mk(8'hBC, 2'd1, 16'h0080, 2'd0);
         5:  return mk(8'h3B, 2'd1, 16'h0000, 2'd0);
         6:  return mk(8'hB0, 2'd1, 16'h0016, 2'd0);
         7:  return mk(8'hB8, 2'd2, 16'hFFF9, 2'd0);
         8:  return mk(8'h11, 2'd0, 16'h0000, 2'd0);
         9:  return mk(8'hBA, 2'd1, 16'h0001, 2'd0);
         10: return mk(8'h3A, 2'd1, 16'h0060, 2'd0);
         11: return mk(8'hB6, 2'd1, 16'h0040, 2'd0);
         12: return mk(8'hEC, 2'd2, 16'h01F0, 2'd0);
         13: return mk(8'h29, 2'd0, 16'h0000, 2'd0);
         14: return mk(8'h28, 2'd0, 16'h0000, 2'd0);
         15: return mk(8'hB8, 2'd2, 16'h8002, 2'd0);
         16: return mk(8'h10, 2'd0, 16'h0000, 2'd0);
         17: return mk(8'hB0, 2'd1, 16'h0000, 2'd0);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/dps_step_rom.sv
module dps_step_rom
   import dps_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);

   if (2 ** IDX_W < ROM_DEPTH) begin : g_bad_idx
      $error("dps_step_rom: IDX_W too narrow for the step table");
   end

   always_comb step = step_at(int'(idx));

endmodule

// File: rtl/dps_ms_timer.sv
module dps_ms_timer #(
   parameter int TICKS_PER_MS = 100_000,
   parameter int DLY_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] ms_in,
   output logic             expire
);

   if (TICKS_PER_MS < 1) begin : g_bad_ticks
      $error("dps_ms_timer: TICKS_PER_MS must be at least 1");
   end

   logic [DLY_W-1:0] rem;
   logic             tick;

   if (TICKS_PER_MS > 1) begin : g_prescale
      localparam int PW = $clog2(TICKS_PER_MS);
      logic [PW-1:0] pre;
      assign tick = (pre == PW'(TICKS_PER_MS - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           pre <= '0;
         else if (load)        pre <= '0;
         else if (rem != '0)   pre <= tick ? '0 : pre + 1'b1;
      end
   end else begin : g_direct
      assign tick = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rem <= '0;
      else if (load)                rem <= ms_in;
      else if (rem != '0 && tick)   rem <= rem - 1'b1;
   end

   assign expire = (rem == DLY_W'(1)) && tick;

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
   import dps_pkg::*;
#(
   parameter int CLK_HZ = 100_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_req,
   input  logic              disable_req,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LEN_W-1:0]  wr_len,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   input  logic              wr_err,
   output logic              busy,
   output logic              active,
   output logic              err_flag
);

   localparam int TICKS_PER_MS = CLK_HZ / 1000;
   localparam int IDX_W        = $clog2(ROM_DEPTH);

   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("disp_pwr_seq: CLK_HZ must be at least 1000");
   end

   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             dir_en;
   logic             active_q;
   logic             err_q;
   step_t            cur;
   logic             expire;

   dps_step_rom #(.IDX_W(IDX_W)) u_rom (
      .idx  (idx),
      .step (cur)
   );

   logic is_pre, at_last, abort, tmr_load, step_done, has_dly;

   assign has_dly   = (cur.dly != '0);
   assign is_pre    = dir_en && (idx < IDX_W'(PRE_COUNT));
   assign at_last   = dir_en ? (idx == IDX_W'(EN_LAST)) : (idx == IDX_W'(DIS_LAST));
   assign abort     = (state == S_ISSUE) && wr_ack && wr_err && is_pre;
   assign tmr_load  = (state == S_ISSUE) && wr_ack && !abort && has_dly;
   assign step_done = ((state == S_ISSUE) && wr_ack && !abort && !has_dly) ||
                      ((state == S_WAIT) && expire);

   dps_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .DLY_W(DLY_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tmr_load),
      .ms_in  (cur.dly),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         dir_en   <= 1'b0;
         active_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (!active_q && enable_req) begin
                  idx    <= IDX_W'(EN_FIRST);
                  dir_en <= 1'b1;
                  err_q  <= 1'b0;
                  state  <= S_ISSUE;
               end else if (active_q && disable_req) begin
                  idx    <= IDX_W'(DIS_FIRST);
                  dir_en <= 1'b0;
                  err_q  <= 1'b0;
                  state  <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (wr_ack) begin
                  if (wr_err)       err_q <= 1'b1;
                  if (abort)        state <= S_IDLE;
                  else if (has_dly) state <= S_WAIT;
               end
            end
            S_WAIT: ;
            default: state <= S_IDLE;
         endcase
         if (step_done) begin
            if (at_last) begin
               state    <= S_IDLE;
               active_q <= dir_en;
            end else begin
               idx   <= idx + 1'b1;
               state <= S_ISSUE;
            end
         end
      end
   end

   assign wr_valid = (state == S_ISSUE);
   assign wr_addr  = cur.addr;
   assign wr_len   = cur.len;
   assign wr_data  = cur.data;
   assign busy     = (state != S_IDLE);
   assign active   = active_q;
   assign err_flag = err_q;

endmodule

// File: rtl/dps_checker.sv
module dps_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        enable_req,
   input logic        disable_req,
   input logic        wr_valid,
   input logic [7:0]  wr_addr,
   input logic [1:0]  wr_len,
   input logic [15:0] wr_data,
   input logic        wr_ack,
   input logic        wr_err,
   input logic        busy,
   input logic        active,
   input logic        err_flag
);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(wr_data));

   assert_len_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_len != 2'd3) &&
                   ((wr_len != 2'd0) || (wr_data == 16'h0000)) &&
                   ((wr_len != 2'd1) || (wr_data[15:8] == 8'h00)));

   assert_rise_on_display_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(wr_valid && wr_ack && wr_addr == 8'h29));

   assert_fall_on_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(wr_valid && wr_ack && wr_addr == 8'hB0));

   assert_pre_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ack && wr_err && wr_addr == 8'h00 |=> !busy && err_flag && !active);

   assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ack && wr_err |=> err_flag);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && busy |=> err_flag);

   assert_enable_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && active && !disable_req |=> !busy);

   assert_disable_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !active && !enable_req |=> !busy);

endmodule

bind disp_pwr_seq dps_checker i_dps_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable_req  (enable_req),
   .disable_req (disable_req),
   .wr_valid    (wr_valid),
   .wr_addr     (wr_addr),
   .wr_len      (wr_len),
   .wr_data     (wr_data),
   .wr_ack      (wr_ack),
   .wr_err      (wr_err),
   .busy        (busy),
   .active      (active),
   .err_flag    (err_flag)
);

// File: tb/test_disp_pwr_seq.sv
module test_disp_pwr_seq;

   localparam int CLK_HZ = 20_000;
   localparam int TICKS  = CLK_HZ / 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable_req = 1'b0;
   logic        disable_req = 1'b0;
   logic        wr_valid;
   logic [7:0]  wr_addr;
   logic [1:0]  wr_len;
   logic [15:0] wr_data;
   logic        wr_ack = 1'b0;
   logic        wr_err = 1'b0;
   logic        busy, active, err_flag;

   always #4 clk = ~clk;

   disp_pwr_seq #(.CLK_HZ(CLK_HZ)) i_disp_pwr_seq (
      .clk, .rst_n, .enable_req, .disable_req,
      .wr_valid, .wr_addr, .wr_len, .wr_data, .wr_ack, .wr_err,
      .busy, .active, .err_flag
   );

   typedef struct {int a; int l; int d; int w; int t;} bstep_t;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bstep_t bs(input int a, input int l, input int d, input int w);
      bstep_t s;
      s.a = a; s.l = l; s.d = d; s.w = w; s.t = 0;
      return s;
   endfunction

   // expected runs, written from the requirements
   function automatic void fill_en(ref bstep_t q[$]);
      q.delete();
      for (int i = 0; i < 3; i++) q.push_back(bs('h00, 0, 0, 1));
      q.push_back(bs('hB0, 1, 'h17, 0));
      q.push_back(bs('hBC, 1, 'h80, 0));
      q.push_back(bs('h3B, 1, 'h00, 0));
      q.push_back(bs('hB0, 1, 'h16, 0));
      q.push_back(bs('hB8, 2, 'hFFF9, 0));
      q.push_back(bs('h11, 0, 0, 0));
      q.push_back(bs('hBA, 1, 'h01, 0));
      q.push_back(bs('h3A, 1, 'h60, 0));
      q.push_back(bs('hB6, 1, 'h40, 0));
      q.push_back(bs('hEC, 2, 'h01F0, 0));
      q.push_back(bs('h29, 0, 0, 0));
   endfunction

   function automatic void fill_dis(ref bstep_t q[$]);
      q.delete();
      q.push_back(bs('h28, 0, 0, 0));
      q.push_back(bs('hB8, 2, 'h8002, 0));
      q.push_back(bs('h10, 0, 0, 0));
      q.push_back(bs('hB0, 1, 'h00, 0));
   endfunction

   // behavioural reference model, advanced on each rising edge
   bstep_t m_q[$];
   bstep_t log_q[$];
   int m_mode = 0;
   int m_wait = 0;
   int m_pos = 0;
   bit m_en = 0, m_active = 0, m_err = 0;

   task automatic m_adv();
      void'(m_q.pop_front());
      m_pos++;
      if (m_q.size() == 0) begin
         m_active = m_en;
         m_mode = 0;
      end else m_mode = 1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_q.delete(); m_mode = 0; m_wait = 0; m_pos = 0; m_active = 0; m_err = 0; m_en = 0;
      end else begin
         if (wr_valid && wr_ack) begin
            bstep_t e;
            e = bs(int'(wr_addr), int'(wr_len), int'(wr_data), 0);
            e.t = cyc;
            log_q.push_back(e);
         end
         case (m_mode)
            0: begin
               if (!m_active && enable_req) begin
                  fill_en(m_q); m_en = 1; m_err = 0; m_pos = 0; m_mode = 1;
               end else if (m_active && disable_req) begin
                  fill_dis(m_q); m_en = 0; m_err = 0; m_pos = 0; m_mode = 1;
               end
            end
            1: begin
               if (wr_ack) begin
                  if (wr_err) m_err = 1;
                  if (wr_err && m_en && m_pos < 3) begin
                     m_q.delete(); m_mode = 0;
                  end else if (m_q[0].w > 0) begin
                     m_wait = m_q[0].w * TICKS; m_mode = 2;
                  end else m_adv();
               end
            end
            default: begin
               m_wait--;
               if (m_wait == 0) m_adv();
            end
         endcase
      end
   end

   // per-cycle comparison, then the writer model, on the falling edge
   int ack_lat = 1;
   int inject_n = -1;
   int wr_count = 0;
   int vcnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 busy", busy, 32'(m_mode != 0));
         chk("R5 active", active, 32'(m_active));
         chk("R6 err_flag", err_flag, 32'(m_err));
         chk("R12 wr_valid", wr_valid, 32'(m_mode == 1));
         if (m_mode == 1) begin
            chk("R4 wr_addr", wr_addr, m_q[0].a);
            chk("R11 wr_len", wr_len, m_q[0].l);
            chk("R11 wr_data", wr_data, m_q[0].d);
         end
      end
      if (wr_ack) begin
         wr_ack = 0; wr_err = 0; vcnt = 0;
      end else if (wr_valid) begin
         if (vcnt >= ack_lat) begin
            wr_ack = 1;
            wr_err = (wr_count == inject_n);
            wr_count++;
            vcnt = 0;
         end else vcnt++;
      end else vcnt = 0;
   end

   task automatic pulse(input bit en);
      @(negedge clk);
      if (en) enable_req = 1; else disable_req = 1;
      @(negedge clk);
      enable_req = 0; disable_req = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic cmp_log(input string tag, input int from, ref bstep_t q[$]);
      chk({tag, " count"}, log_q.size() - from, q.size());
      for (int i = 0; i < q.size() && from + i < log_q.size(); i++) begin
         chk({tag, " addr"}, log_q[from+i].a, q[i].a);
         chk({tag, " len"}, log_q[from+i].l, q[i].l);
         chk({tag, " data"}, log_q[from+i].d, q[i].d);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      bstep_t exp_q[$];
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 active", active, 0);
      chk("R1 err_flag", err_flag, 0);
      chk("R1 wr_valid", wr_valid, 0);

      // R2 R4 R5: clean enable run
      base = log_q.size();
      pulse(1);
      wait_idle();
      fill_en(exp_q);
      cmp_log("R4 enable", base, exp_q);
      chk("R5 active after run", active, 1);
      chk("R6 no error", err_flag, 0);
      chk("R2 pause after first", 32'(log_q[base+1].t - log_q[base].t > TICKS), 1);
      chk("R2 pause after third", 32'(log_q[base+3].t - log_q[base+2].t > TICKS), 1);

      // R8: enable while already active
      base = log_q.size();
      pulse(1);
      chk("R8 busy on redundant enable", busy, 0);
      repeat (5) @(negedge clk);
      chk("R8 no writes", log_q.size() - base, 0);

      // R7 R9 R12: shutdown with slow writer and an enable request mid-run
      ack_lat = 3;
      base = log_q.size();
      pulse(0);
      repeat (4) @(negedge clk);
      pulse(1);
      wait_idle();
      fill_dis(exp_q);
      cmp_log("R7 disable", base, exp_q);
      chk("R9 request ignored while busy", active, 0);
      chk("R9 idle after shutdown", busy, 0);

      // R8: disable while already inactive
      base = log_q.size();
      pulse(0);
      repeat (5) @(negedge clk);
      chk("R8 no writes on redundant disable", log_q.size() - base, 0);

      // R3: error on second preamble write
      ack_lat = 0;
      base = log_q.size();
      inject_n = wr_count + 1;
      pulse(1);
      wait_idle();
      chk("R3 writes before abort", log_q.size() - base, 2);
      chk("R3 inactive", active, 0);
      chk("R3 error flag", err_flag, 1);

      // R10 R6: new enable clears the flag, then a late error keeps the run going
      base = log_q.size();
      inject_n = wr_count + 6;
      pulse(1);
      chk("R10 cleared on new request", err_flag, 0);
      wait_idle();
      fill_en(exp_q);
      cmp_log("R6 enable with error", base, exp_q);
      chk("R6 active despite error", active, 1);
      chk("R6 error flag", err_flag, 1);
      repeat (10) @(negedge clk);
      chk("R10 sticky while idle", err_flag, 1);
      pulse(0);
      chk("R10 cleared by disable", err_flag, 0);
      wait_idle();
      chk("R7 inactive", active, 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule